// File: doc/BRIEF.md
# Programmable Parallel Port Core

This block is a parallel I/O peripheral that a processor reaches over a small 8-bit register bus. It offers three 8-bit ports, named A, B and C, and one configuration register. The processor sets port A, port B and each half of port C to input or output, one at a time and independently. Output values sit in latches. Input values go from the pins to the read data with no register in between. The block has no tri-state pads. Each port line has an output value and an output-enable, and the pad ring outside the block does the driving.

One write to the configuration address does one of two things, chosen by the top bit of the byte. With the top bit set, the write replaces the whole configuration. With it clear, the write sets or clears a single port C line and nothing else. Port A and the upper half of port C form group A. Port B and the lower half of port C form group B. The group mode fields are stored and read back. Only basic I/O behaviour is carried out. All state changes on the rising edge of one system clock.

Top module: `pario_core`

## Requirements
- R1: The address selects the target: 0 is port A, 1 is port B, 2 is port C and 3 is the configuration register. A write changes only the selected target.
- R2: The block ignores any read or write while `cs_n` is high. `rd_n` and `wr_n` are active low. `rdata` is 0 whenever chip select and the read strobe are not both low.
- R3: While `rst` is high, and just after it falls, every output-enable is 0 and every output latch is 0. The configuration register reads back 9Bh, which means basic mode with all ports as inputs.
- R4: A configuration write with bit 7 set does the following:
  - bits 6:5 become the group A mode and bit 2 becomes the group B mode;
  - bit 4 sets the direction of port A, bit 3 of port C bits 7:4, bit 1 of port B, and bit 0 of port C bits 3:0;
  - a direction bit of 1 means input (output-enable 0), and 0 means output (output-enable 1).
- R5: A configuration write with bit 7 clear sets port C line number bits 3:1 to the value of bit 0. It changes no other port C line and does not change the configuration.
- R6: A configuration write with bit 7 set clears all three output latches to 0.
- R7: A read of a port, or of a port C half, that is set as input returns the pin value in the same cycle, with no latching.
- R8: A write to port A, B or C loads that latch on the clock edge, whatever its direction. A read of a port or half set as output returns the latch.
- R9: A read of address 3 returns the last configuration byte, with bit 7 always set.
- R10: Each half of port C follows only its own direction bit. Its four output-enables are always all 0 or all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register select |
| wdata | input | 8 | Write data from the processor |
| rdata | output | 8 | Read data to the processor; 0 when not reading |
| pa_in | input | 8 | Port A pin values |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A output-enables |
| pb_in | input | 8 | Port B pin values |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B output-enables |
| pc_in | input | 8 | Port C pin values |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C output-enables |

## Verification
A wrong configuration bit shows up on the output-enables on the very next clock. It also shows as a wrong read of address 3, or as a read that returns the latch instead of the pins. A corrupted latch shows directly on the port outputs one cycle after the write. A set/reset command that touches the wrong line shows as a changed port C output on the following cycle. The bench compares every output against its own model after every cycle, so each such fault appears within one clock of its cause.

// File: rtl/pario_pkg.sv
package pario_pkg;

    localparam int PW     = 8;
    localparam int AW     = 2;
    localparam int NSEL   = 4;
    localparam int HALF   = PW / 2;
    localparam int IDX_W  = $clog2(PW);

    typedef enum logic [AW-1:0] {
        SEL_A   = 2'd0,
        SEL_B   = 2'd1,
        SEL_C   = 2'd2,
        SEL_CFG = 2'd3
    } sel_e;

    // Field order follows the bit positions of the configuration byte (6..0).
    typedef struct packed {
        logic [1:0] grp_a_mode;
        logic       a_is_in;
        logic       cu_is_in;
        logic       grp_b_mode;
        logic       b_is_in;
        logic       cl_is_in;
    } cfg_t;

    localparam cfg_t CFG_RST = '{
        grp_a_mode: 2'b00,
        a_is_in:    1'b1,
        cu_is_in:   1'b1,
        grp_b_mode: 1'b0,
        b_is_in:    1'b1,
        cl_is_in:   1'b1
    };

endpackage

// File: rtl/pario_decode.sv
module pario_decode
    import pario_pkg::*;
(
    input  logic            cs_n,
    input  logic            rd_n,
    input  logic            wr_n,
    input  logic [AW-1:0]   addr,
    output logic [NSEL-1:0] wr_sel,
    output logic            rd_act
);

    logic wr_act;

    assign wr_act = ~cs_n & ~wr_n;
    assign rd_act = ~cs_n & ~rd_n;

    for (genvar i = 0; i < NSEL; i++) begin : g_sel
        localparam logic [AW-1:0] SEL_CODE = AW'(i);
        assign wr_sel[i] = wr_act & (addr == SEL_CODE);
    end

endmodule

// File: rtl/pario_ctrl.sv
module pario_ctrl
    import pario_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_cfg,
    input  logic [PW-1:0]    wdata,
    output cfg_t             cfg,
    output logic             mode_wr,
    output logic             bsr_wr,
    output logic [IDX_W-1:0] bsr_idx,
    output logic             bsr_val
);

    typedef struct packed {
        cfg_t cfg;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    assign mode_wr = wr_cfg &  wdata[PW-1];
    assign bsr_wr  = wr_cfg & ~wdata[PW-1];
    assign bsr_idx = wdata[IDX_W:1];
    assign bsr_val = wdata[0];

    always_comb begin
        st_d = st_q;
        if (mode_wr) begin
            st_d.cfg = cfg_t'(wdata[PW-2:0]);
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            st_q.cfg <= CFG_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg = st_q.cfg;

    // A set/reset command never alters the stored configuration.
    p_bsr_keeps_cfg_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_cfg && !wdata[PW-1]) |=> $stable(st_q.cfg));

    // A mode definition becomes visible one cycle later.
    p_mode_loads_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_cfg && wdata[PW-1]) |=> (st_q.cfg == $past(wdata[PW-2:0])));

endmodule

// File: rtl/pario_latch.sv
module pario_latch #(
    parameter int W  = 8,
    parameter int IW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          wr,
    input  logic [W-1:0]  wdata,
    input  logic          bit_wr,
    input  logic [IW-1:0] bit_idx,
    input  logic          bit_val,
    output logic [W-1:0]  q
);

    typedef struct packed {
        logic [W-1:0] val;
    } latch_st_t;

    latch_st_t    st_d, st_q;
    logic [W-1:0] nxt;

    for (genvar i = 0; i < W; i++) begin : g_bit
        localparam logic [IW-1:0] BIT_CODE = IW'(i);
        always_comb begin
            if (clr) begin
                nxt[i] = 1'b0;
            end else if (wr) begin
                nxt[i] = wdata[i];
            end else if (bit_wr && (bit_idx == BIT_CODE)) begin
                nxt[i] = bit_val;
            end else begin
                nxt[i] = st_q.val[i];
            end
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.val = nxt;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            st_q.val <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.val;

    p_clear_zero_r6: assert property (@(posedge clk) disable iff (rst)
        clr |=> (q == '0));

    p_single_bit_r5: assert property (@(posedge clk) disable iff (rst)
        (bit_wr && !wr && !clr) |=> ($countones(q ^ $past(q)) <= 1));

endmodule

// File: rtl/pario_core.sv
module pario_core
    import pario_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [AW-1:0] addr,
    input  logic [PW-1:0] wdata,
    output logic [PW-1:0] rdata,
    input  logic [PW-1:0] pa_in,
    output logic [PW-1:0] pa_out,
    output logic [PW-1:0] pa_oe,
    input  logic [PW-1:0] pb_in,
    output logic [PW-1:0] pb_out,
    output logic [PW-1:0] pb_oe,
    input  logic [PW-1:0] pc_in,
    output logic [PW-1:0] pc_out,
    output logic [PW-1:0] pc_oe
);

    logic [NSEL-1:0]  wr_sel;
    logic             rd_act;
    cfg_t             cfg;
    logic             mode_wr;
    logic             bsr_wr;
    logic [IDX_W-1:0] bsr_idx;
    logic             bsr_val;
    logic [PW-1:0]    a_q, b_q, c_q;
    logic [PW-1:0]    cfg_byte;

    pario_decode u_decode (
        .cs_n   (cs_n),
        .rd_n   (rd_n),
        .wr_n   (wr_n),
        .addr   (addr),
        .wr_sel (wr_sel),
        .rd_act (rd_act)
    );

    pario_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_cfg  (wr_sel[SEL_CFG]),
        .wdata   (wdata),
        .cfg     (cfg),
        .mode_wr (mode_wr),
        .bsr_wr  (bsr_wr),
        .bsr_idx (bsr_idx),
        .bsr_val (bsr_val)
    );

    pario_latch #(.W(PW)) u_lat_a (
        .clk (clk), .rst (rst), .clr (mode_wr), .wr (wr_sel[SEL_A]),
        .wdata (wdata), .bit_wr (1'b0), .bit_idx ('0), .bit_val (1'b0),
        .q (a_q)
    );

    pario_latch #(.W(PW)) u_lat_b (
        .clk (clk), .rst (rst), .clr (mode_wr), .wr (wr_sel[SEL_B]),
        .wdata (wdata), .bit_wr (1'b0), .bit_idx ('0), .bit_val (1'b0),
        .q (b_q)
    );

    pario_latch #(.W(PW)) u_lat_c (
        .clk (clk), .rst (rst), .clr (mode_wr), .wr (wr_sel[SEL_C]),
        .wdata (wdata), .bit_wr (bsr_wr), .bit_idx (bsr_idx), .bit_val (bsr_val),
        .q (c_q)
    );

    assign pa_out = a_q;
    assign pb_out = b_q;
    assign pc_out = c_q;

    assign pa_oe = {PW{~cfg.a_is_in}};
    assign pb_oe = {PW{~cfg.b_is_in}};
    assign pc_oe = {{HALF{~cfg.cu_is_in}}, {HALF{~cfg.cl_is_in}}};

    assign cfg_byte = {1'b1, cfg};

    always_comb begin
        rdata = '0;
        if (rd_act) begin
            unique case (sel_e'(addr))
                SEL_A:   rdata = cfg.a_is_in ? pa_in : a_q;
                SEL_B:   rdata = cfg.b_is_in ? pb_in : b_q;
                SEL_C:   rdata = {cfg.cu_is_in ? pc_in[PW-1:HALF] : c_q[PW-1:HALF],
                                  cfg.cl_is_in ? pc_in[HALF-1:0]  : c_q[HALF-1:0]};
                SEL_CFG: rdata = cfg_byte;
                default: rdata = '0;
            endcase
        end
    end

    p_one_target_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_sel));

    p_idle_no_change_r2: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out) && $stable(pc_oe)));

    p_idle_read_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (cs_n || rd_n) |-> (rdata == '0));

    p_nibble_oe_r10: assert property (@(posedge clk) disable iff (rst)
        ((pc_oe[PW-1:HALF] == '0) || (pc_oe[PW-1:HALF] == '1)) &&
        ((pc_oe[HALF-1:0] == '0) || (pc_oe[HALF-1:0] == '1)));

endmodule

// File: tb/pario_core_bench.sv
module pario_core_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic [7:0] pa_in = 8'd0, pb_in = 8'd0, pc_in = 8'd0;
    logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

    int n_vec  = 0;
    int n_fail = 0;

    // reference model state
    logic [7:0] m_cfg;
    logic [7:0] m_a, m_b, m_c;

    always #10 clk = ~clk;

    pario_core u_pario_core (
        .clk (clk), .rst (rst), .cs_n (cs_n), .rd_n (rd_n), .wr_n (wr_n),
        .addr (addr), .wdata (wdata), .rdata (rdata),
        .pa_in (pa_in), .pa_out (pa_out), .pa_oe (pa_oe),
        .pb_in (pb_in), .pb_out (pb_out), .pb_oe (pb_oe),
        .pc_in (pc_in), .pc_out (pc_out), .pc_oe (pc_oe)
    );

    always @(posedge clk or posedge rst) begin
        if (rst) begin
            m_cfg <= 8'h9B;
            m_a   <= 8'h00;
            m_b   <= 8'h00;
            m_c   <= 8'h00;
        end else if (!cs_n && !wr_n) begin
            if (addr == 2'd0) m_a <= wdata;
            else if (addr == 2'd1) m_b <= wdata;
            else if (addr == 2'd2) m_c <= wdata;
            else if (wdata[7]) begin
                m_cfg <= wdata;
                m_a <= 8'h00; m_b <= 8'h00; m_c <= 8'h00;
            end else begin
                m_c[wdata[3:1]] <= wdata[0];
            end
        end
    end

    function automatic logic [55:0] expect_all();
        logic [7:0] rd;
        rd = 8'h00;
        if (!cs_n && !rd_n) begin
            case (addr)
                2'd0: rd = m_cfg[4] ? pa_in : m_a;
                2'd1: rd = m_cfg[1] ? pb_in : m_b;
                2'd2: rd = {m_cfg[3] ? pc_in[7:4] : m_c[7:4],
                            m_cfg[0] ? pc_in[3:0] : m_c[3:0]};
                default: rd = m_cfg;
            endcase
        end
        return {rd, m_a, {8{~m_cfg[4]}}, m_b, {8{~m_cfg[1]}}, m_c,
                {{4{~m_cfg[3]}}, {4{~m_cfg[0]}}}};
    endfunction

    task automatic compare(input string tag);
        logic [55:0] act, exp;
        act = {rdata, pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe};
        exp = expect_all();
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (rdata,pa,pa_oe,pb,pb_oe,pc,pc_oe)",
                     tag, act, exp);
        end
    endtask

    // Drive one bus cycle after the falling clock edge, compare mid-phase.
    task automatic cyc(input string tag, input logic cs, input logic rd, input logic wr,
                       input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cs_n = cs; rd_n = rd; wr_n = wr; addr = a; wdata = d;
        #2;
        compare(tag);
    endtask

    task automatic wr_reg(input string tag, input logic [1:0] a, input logic [7:0] d);
        cyc(tag, 1'b0, 1'b1, 1'b0, a, d);
        cyc(tag, 1'b1, 1'b1, 1'b1, 2'd0, 8'h00);
    endtask

    task automatic rd_reg(input string tag, input logic [1:0] a);
        cyc(tag, 1'b0, 1'b0, 1'b1, a, 8'h00);
    endtask

    initial begin
        #3_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        pa_in = 8'hC3; pb_in = 8'h3C; pc_in = 8'hA5;
        repeat (3) @(negedge clk);
        #2; compare("R3 during reset");
        rst = 1'b0;
        cyc("R3 after reset", 1'b1, 1'b1, 1'b1, 2'd0, 8'h00);
        rd_reg("R3 R9 cfg readback", 2'd3);
        rd_reg("R7 read A pins", 2'd0);
        rd_reg("R7 read B pins", 2'd1);
        rd_reg("R7 read C pins", 2'd2);
        pb_in = 8'h77;
        rd_reg("R7 pin change seen same cycle", 2'd1);
        wr_reg("R8 R1 write B while input", 2'd1, 8'h96);
        rd_reg("R8 B input reads pins", 2'd1);
        wr_reg("R4 R6 mode 8B", 2'd3, 8'h8B);
        rd_reg("R9 cfg 8B", 2'd3);
        wr_reg("R1 R8 write A", 2'd0, 8'h5A);
        rd_reg("R8 read A latch", 2'd0);
        cyc("R2 write with cs high", 1'b1, 1'b1, 1'b0, 2'd0, 8'hFF);
        cyc("R2 read with cs high", 1'b1, 1'b0, 1'b1, 2'd0, 8'h00);
        rd_reg("R2 A unchanged", 2'd0);
        wr_reg("R4 R6 mode all out", 2'd3, 8'h80);
        wr_reg("R1 write C", 2'd2, 8'h0F);
        wr_reg("R5 set C bit 7", 2'd3, 8'h0F);
        wr_reg("R5 clear C bit 0", 2'd3, 8'h00);
        wr_reg("R5 set C bit 4", 2'd3, 8'h09);
        rd_reg("R5 R9 cfg unchanged", 2'd3);
        rd_reg("R5 read C", 2'd2);
        wr_reg("R10 R4 mode C low in", 2'd3, 8'h81);
        wr_reg("R10 write C", 2'd2, 8'hE7);
        rd_reg("R10 mixed C read", 2'd2);
        wr_reg("R10 R4 mode C high in groups", 2'd3, 8'hE8);
        rd_reg("R10 R9 mixed C read 2", 2'd2);
        wr_reg("R6 write B", 2'd1, 8'h3E);
        wr_reg("R6 remode clears", 2'd3, 8'h92);
        rd_reg("R6 read B after clear", 2'd1);
        for (int k = 0; k < 2000; k++) begin
            pa_in = 8'($urandom); pb_in = 8'($urandom); pc_in = 8'($urandom);
            cyc("R1 R2 R4 R5 R7 R8 random", 1'($urandom), 1'($urandom),
                1'($urandom), 2'($urandom), 8'($urandom));
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule